// File: doc/BRIEF.md
# Multicolumn Set-Associative Cache Lookup

This block is a four-way set-associative cache holding both tags and line data. Every address owns one preferred way, its *home way*, given by the two lowest tag bits. The home way is checked on its own in the first lookup cycle, so a block that sits in its home way answers with the same one-cycle latency as a direct-mapped cache. When the home way misses, the other three ways are checked in a second cycle.

A hit found in another way swaps that block into its home way. A miss fetches the whole line over a simple memory port and installs it in the home way. If the home way already holds a block, that block is moved to a *spill way* of the same set, so it is kept rather than dropped. A small per-set pointer names the spill way and advances round-robin after each spill. A processor-side requester uses the request port one access at a time. A line refill source answers the memory port.

Top module: `mc_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. Every line is invalid, so the first access to any address misses.
- R2: The address is split as follows. Bits [1:0] are the byte offset. Bits [5:2] select the 32-bit word within a 16-word line. Bits [10:6] are the set index. Bits [31:11] are the tag. Address bits [12:11], the two lowest tag bits, name the home way (0 to 3). At most one way of a set matches a tag.
- R3: When the home way holds the block, `rsp_valid` is high in the cycle right after the accepting edge, and no memory request is made.
- R4: When another way of the set holds the block, `rsp_valid` comes one cycle later than in R3. That block then moves into the home way, and the former home-way occupant moves into the way the hit came from.
- R5: On a miss, `mem_req_valid` rises with the line-aligned address (`{tag, set, 6'b0}`) in the second cycle after acceptance. It holds steady until `mem_req_ready`. The next 16 `mem_rvalid` words fill the line in word order. The response follows in the cycle after the last word, and the new block sits in its home way.
- R6: A valid block displaced from the home way by a miss is moved to the spill way of the same set, never to the home way. Any block previously in the spill way is evicted.
- R7: Each set has a spill pointer, reset to way 0. If the pointer equals the home way, the spill uses the next way. After a spill, the pointer advances to the way after the one used, skipping the home way.
- R8: A write stores `req_wdata` into the addressed word on every path (home hit, other-way hit, miss after fill). Its response returns the written value. A read returns the stored word.
- R9: `req_ready` is low from the accepting edge until the edge that raises the response. A response is only raised while `req_ready` is high again.
- R10: Line data, including earlier writes, is carried intact through swaps and spills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read word, or the written word for writes |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Fetch request taken |
| mem_req_addr | output | 32 | Line-aligned fetch address |
| mem_rvalid | input | 1 | Fill word present |
| mem_rdata | input | 32 | Fill word |

## Verification
The hardest state to reach from the ports is a spill that evicts a valid block while the spill pointer wraps around and steps over the home way. Reaching it needs several distinct tags that share both the set and the home way. The stimulus streams five such tags into one set, then revisits the first tag and expects a full miss. Swaps are exercised by alternating between two same-home tags, with a written word checked after each move.

// File: rtl/mc_cache_pkg.sv
package mc_cache_pkg;
    // Controller phases of one access
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,  // home-way probe on the incoming request
        S_PROBE = 2'd1,  // second probe of the other ways
        S_MREQ  = 2'd2,  // line fetch request outstanding
        S_FILL  = 2'd3   // collecting line words
    } mc_state_e;
endpackage

// File: rtl/mc_cache_tagcmp.sv
// Tag comparator for one set row.
// Compares a lookup tag against every way and returns the hit vector,
// a hit flag and the encoded way. Assumes tags in a set are unique.
module mc_cache_tagcmp #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 21,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row_tags,
    input  logic [WAYS-1:0]            row_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = row_valid[g] && (row_tags[g] == look_tag);
    end

    // Encode the matching way (at most one is expected)
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/mc_cache_selptr.sv
// Per-set spill pointer.
// Names the way that receives a block displaced from the home way,
// stepping over the home way, and advances round-robin on each spill.
// Assumes WAYS is a power of two so the pointer wraps naturally.
module mc_cache_selptr #(
    parameter int SETS = 32,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [WAY_W-1:0] major_way,
    input  logic             advance,
    output logic [WAY_W-1:0] target_way
);
    logic [WAY_W-1:0] ptr_q [SETS];
    logic [WAY_W-1:0] cur;
    logic [WAY_W-1:0] nxt;

    // Pick the spill way and its successor, both avoiding the home way
    always_comb begin
        cur        = ptr_q[set_idx];
        target_way = (cur == major_way) ? cur + WAY_W'(1) : cur;
        nxt        = target_way + WAY_W'(1);
        if (nxt == major_way) nxt = nxt + WAY_W'(1);
    end

    // Pointer storage: cleared on reset, advanced after a spill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '{default: '0};
        end else if (advance) begin
            ptr_q[set_idx] <= nxt;
        end
    end

    // R7: after a spill the pointer names neither the way used nor the home way
    p_ptr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ptr_q[$past(set_idx)] != $past(target_way)) &&
                    (ptr_q[$past(set_idx)] != $past(major_way)));
endmodule

// File: rtl/mc_cache_fillbuf.sv
// Line fill buffer.
// Gathers LINE_WORDS sequential words; exposes the line including the
// word arriving this cycle so the last word can be installed directly.
module mc_cache_fillbuf #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 16,
    localparam int CNT_W = $clog2(LINE_WORDS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear,
    input  logic                                in_valid,
    input  logic [WORD_W-1:0]                   in_data,
    output logic [LINE_WORDS-1:0][WORD_W-1:0]   line_o,
    output logic                                last_o
);
    logic [CNT_W-1:0]                 cnt_q;
    logic [LINE_WORDS-1:0][WORD_W-1:0] buf_q;

    // Word counter: restarts on clear, steps per accepted word
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Word storage
    always_ff @(posedge clk) begin
        if (in_valid) buf_q[cnt_q] <= in_data;
    end

    // Line view with the current word merged in
    always_comb begin
        line_o = buf_q;
        if (in_valid) line_o[cnt_q] = in_data;
    end

    assign last_o = in_valid && (cnt_q == CNT_W'(LINE_WORDS - 1));

    // R5: the final word of a line restarts the count
    p_fill_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clear && cnt_q == CNT_W'(LINE_WORDS - 1)) |=> (cnt_q == '0));
endmodule

// File: rtl/mc_cache.sv
// Multicolumn set-associative cache, top level.
// Probes the home way first (one cycle), other ways second; swaps
// other-way hits home; fills misses into the home way, spilling the
// previous occupant into the set's spill way. One access at a time.
// Assumes the memory port delivers exactly one line per request.
module mc_cache
    import mc_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 16,
    parameter int SETS       = 32,
    parameter int WAYS       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    // Storage
    logic [WAYS-1:0]   valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WORD_W-1:0] data_q  [SETS][WAYS][LINE_WORDS];

    // Control and latched request
    mc_state_e         state_q;
    logic              lat_write;
    logic [WORD_W-1:0] lat_wdata;
    logic [TAG_W-1:0]  lat_tag;
    logic [IDX_W-1:0]  lat_idx;
    logic [WSEL_W-1:0] lat_wsel;
    logic [WAY_W-1:0]  lat_maj;

    // Incoming request fields
    logic [WSEL_W-1:0] r_wsel;
    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;
    logic [WAY_W-1:0]  r_maj;
    logic              unused_byte_bits;

    assign r_wsel = req_addr[OFF_W-1:BYTE_W];
    assign r_idx  = req_addr[OFF_W+IDX_W-1:OFF_W];
    assign r_tag  = req_addr[ADDR_W-1:OFF_W+IDX_W];
    assign r_maj  = r_tag[WAY_W-1:0];
    assign unused_byte_bits = ^req_addr[BYTE_W-1:0];

    // Lookup row selection
    logic [IDX_W-1:0]            lk_idx;
    logic [TAG_W-1:0]            lk_tag;
    logic [WAYS-1:0][TAG_W-1:0]  row_tags;
    logic [WAYS-1:0]             row_valid;
    logic [WAYS-1:0]             hit_vec;
    logic                        any_hit;
    logic [WAY_W-1:0]            hit_way;

    // Choose which request drives the comparator and read its row
    always_comb begin
        lk_idx    = (state_q == S_IDLE) ? r_idx : lat_idx;
        lk_tag    = (state_q == S_IDLE) ? r_tag : lat_tag;
        row_valid = valid_q[lk_idx];
        for (int w = 0; w < WAYS; w++) begin
            row_tags[w] = tag_q[lk_idx][WAY_W'(w)];
        end
    end

    mc_cache_tagcmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_tagcmp (
        .row_tags (row_tags),
        .row_valid(row_valid),
        .look_tag (lk_tag),
        .hit_vec  (hit_vec),
        .any_hit  (any_hit),
        .hit_way  (hit_way)
    );

    // Fill path
    logic [LINE_WORDS-1:0][WORD_W-1:0] fill_line;
    logic                              fill_last;
    logic                              fill_clear;
    logic                              fill_in;

    assign fill_clear = (state_q == S_MREQ);
    assign fill_in    = (state_q == S_FILL) && mem_rvalid;

    mc_cache_fillbuf #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_fillbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (fill_clear),
        .in_valid(fill_in),
        .in_data (mem_rdata),
        .line_o  (fill_line),
        .last_o  (fill_last)
    );

    // Action strobes
    logic             major_hit;
    logic             do_fast;
    logic             do_probe;
    logic             do_swap;
    logic             do_fill;
    logic             do_reloc;
    logic [WAY_W-1:0] reloc_way;

    assign major_hit = hit_vec[r_maj];
    assign do_fast   = (state_q == S_IDLE) && req_valid && major_hit;
    assign do_probe  = (state_q == S_IDLE) && req_valid && !major_hit;
    assign do_swap   = (state_q == S_PROBE) && any_hit;
    assign do_fill   = (state_q == S_FILL) && fill_last;
    assign do_reloc  = do_fill && valid_q[lat_idx][lat_maj];

    mc_cache_selptr #(.SETS(SETS), .WAYS(WAYS)) u_selptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (lat_idx),
        .major_way (lat_maj),
        .advance   (do_reloc),
        .target_way(reloc_way)
    );

    assign req_ready     = (state_q == S_IDLE);
    assign mem_req_valid = (state_q == S_MREQ);
    assign mem_req_addr  = {lat_tag, lat_idx, {OFF_W{1'b0}}};

    // Sequencing, request capture and response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            lat_write <= 1'b0;
            lat_wdata <= '0;
            lat_tag   <= '0;
            lat_idx   <= '0;
            lat_wsel  <= '0;
            lat_maj   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (do_fast) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= req_write ? req_wdata : data_q[r_idx][r_maj][r_wsel];
                    end else if (do_probe) begin
                        lat_write <= req_write;
                        lat_wdata <= req_wdata;
                        lat_tag   <= r_tag;
                        lat_idx   <= r_idx;
                        lat_wsel  <= r_wsel;
                        lat_maj   <= r_maj;
                        state_q   <= S_PROBE;
                    end
                end
                S_PROBE: begin
                    if (do_swap) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= lat_write ? lat_wdata : data_q[lat_idx][hit_way][lat_wsel];
                        state_q   <= S_IDLE;
                    end else begin
                        state_q <= S_MREQ;
                    end
                end
                S_MREQ: begin
                    if (mem_req_ready) state_q <= S_FILL;
                end
                S_FILL: begin
                    if (do_fill) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= lat_write ? lat_wdata : fill_line[lat_wsel];
                        state_q   <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Valid bits: cleared on reset, moved by swaps, set by fills and spills
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '{default: '0};
        end else if (do_swap) begin
            valid_q[lat_idx][lat_maj] <= valid_q[lat_idx][hit_way];
            valid_q[lat_idx][hit_way] <= valid_q[lat_idx][lat_maj];
        end else if (do_fill) begin
            valid_q[lat_idx][lat_maj] <= 1'b1;
            if (do_reloc) valid_q[lat_idx][reloc_way] <= 1'b1;
        end
    end

    // Tags and line data: home-hit writes, swaps, spills and fills
    always_ff @(posedge clk) begin
        if (do_fast && req_write) begin
            data_q[r_idx][r_maj][r_wsel] <= req_wdata;
        end
        if (do_swap) begin
            tag_q[lat_idx][lat_maj] <= tag_q[lat_idx][hit_way];
            tag_q[lat_idx][hit_way] <= tag_q[lat_idx][lat_maj];
            for (int w = 0; w < LINE_WORDS; w++) begin
                data_q[lat_idx][lat_maj][WSEL_W'(w)] <= data_q[lat_idx][hit_way][WSEL_W'(w)];
                data_q[lat_idx][hit_way][WSEL_W'(w)] <= data_q[lat_idx][lat_maj][WSEL_W'(w)];
            end
            if (lat_write) data_q[lat_idx][lat_maj][lat_wsel] <= lat_wdata;
        end
        if (do_fill) begin
            if (do_reloc) begin
                tag_q[lat_idx][reloc_way] <= tag_q[lat_idx][lat_maj];
                for (int w = 0; w < LINE_WORDS; w++) begin
                    data_q[lat_idx][reloc_way][WSEL_W'(w)] <= data_q[lat_idx][lat_maj][WSEL_W'(w)];
                end
            end
            tag_q[lat_idx][lat_maj] <= lat_tag;
            for (int w = 0; w < LINE_WORDS; w++) begin
                data_q[lat_idx][lat_maj][WSEL_W'(w)] <= fill_line[w];
            end
            if (lat_write) data_q[lat_idx][lat_maj][lat_wsel] <= lat_wdata;
        end
    end

    // Any valid line anywhere, for the reset check
    logic any_valid;
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[IDX_W'(s)]);
    end

    // R1: the cycle after reset no line is valid
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !any_valid);

    // R2: a tag never matches two ways of one set
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R3: a home-way hit answers on the next cycle
    p_fast_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid && major_hit) |=> rsp_valid);

    // R5: fetch request is held with a stable address until taken
    p_memreq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6: a spill never lands in the home way
    p_spill_not_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
        do_reloc |-> (reloc_way != lat_maj));

    // R9: responses only appear when the block is free again
    p_rsp_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
endmodule

// File: tb/mc_cache_bench.sv
`timescale 1ns/1ps
module mc_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    mc_cache u_mc_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int mem_reqs = 0;
    logic [31:0] last_mem_addr = '0;

    // Reference contents, per set and way
    bit [20:0] rtag [32][4];
    bit        rval [32][4];
    bit [31:0] rdat [32][4][16];
    int        rsel [32];

    function automatic [31:0] memf(input [31:0] la, input int k);
        return (la * 32'h0001_9E37) ^ (32'(k) << 20) ^ (32'h1234_5678 + 32'(k));
    endfunction

    function automatic [31:0] mk(input [20:0] tg, input int ix, input int ws);
        return {tg, ix[4:0], ws[3:0], 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input [31:0] act, input [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory side: one line of 16 words, starting the negedge after the request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [31:0] la;
                la = mem_req_addr;
                last_mem_addr = la;
                mem_reqs++;
                for (int k = 0; k < 16; k++) begin
                    @(negedge clk);
                    mem_rvalid = 1'b1;
                    mem_rdata  = memf(la, k);
                end
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    // One access: predict from the model, drive, measure latency, compare
    task automatic access(input bit wr, input [31:0] addr, input [31:0] wd, input string why);
        bit [20:0] tg;
        int ix, ws, mj, found, elat, lat, m0, t, n;
        bit [31:0] exp;
        logic busy_ready;
        string lreq;
        tg = addr[31:11]; ix = addr[10:6]; ws = addr[5:2]; mj = addr[12:11];
        found = -1;
        for (int w = 0; w < 4; w++) if (rval[ix][w] && rtag[ix][w] == tg) found = w;
        if (found == mj) begin
            elat = 1; lreq = "R3";
        end else if (found >= 0) begin
            elat = 2; lreq = "R4";
            begin
                bit [20:0] tt; bit tv; bit [31:0] td;
                tt = rtag[ix][mj]; rtag[ix][mj] = rtag[ix][found]; rtag[ix][found] = tt;
                tv = rval[ix][mj]; rval[ix][mj] = rval[ix][found]; rval[ix][found] = tv;
                for (int k = 0; k < 16; k++) begin
                    td = rdat[ix][mj][k]; rdat[ix][mj][k] = rdat[ix][found][k]; rdat[ix][found][k] = td;
                end
            end
        end else begin
            elat = 19; lreq = "R5";
            if (rval[ix][mj]) begin
                t = rsel[ix];
                if (t == mj) t = (t + 1) % 4;
                rtag[ix][t] = rtag[ix][mj]; rval[ix][t] = 1'b1;
                for (int k = 0; k < 16; k++) rdat[ix][t][k] = rdat[ix][mj][k];
                n = (t + 1) % 4;
                if (n == mj) n = (n + 1) % 4;
                rsel[ix] = n;
            end
            rtag[ix][mj] = tg; rval[ix][mj] = 1'b1;
            for (int k = 0; k < 16; k++) rdat[ix][mj][k] = memf({addr[31:6], 6'b0}, k);
        end
        if (wr) rdat[ix][mj][ws] = wd;
        exp = rdat[ix][mj][ws];
        m0 = mem_reqs;
        busy_ready = 1'b1;

        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 60) begin
            if (lat == 2) busy_ready = req_ready;
            @(negedge clk);
            lat++;
        end
        check(lat == elat, {lreq, " latency ", why}, 32'(lat), 32'(elat));
        check(rsp_rdata == exp, {wr ? "R8" : "R10", " data ", why}, rsp_rdata, exp);
        check(mem_reqs == m0 + (elat == 19 ? 1 : 0), {lreq, " fetch count ", why},
              32'(mem_reqs - m0), 32'(elat == 19 ? 1 : 0));
        if (elat == 19) begin
            check(last_mem_addr == {addr[31:6], 6'b0}, {"R5 fetch address ", why},
                  last_mem_addr, {addr[31:6], 6'b0});
            check(busy_ready == 1'b0, {"R9 busy ready ", why}, 32'(busy_ready), 32'd0);
        end
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
        access(1'b0, mk(21'h000100, 3, 0), 32'h0, "R1 first access misses");
    endtask

    task automatic t_home_hits();
        access(1'b0, mk(21'h000100, 3, 0), 32'h0, "R3 home hit word0");
        access(1'b0, mk(21'h000100, 3, 15), 32'h0, "R2 R3 home hit word15");
        access(1'b1, mk(21'h000100, 3, 5), 32'hCAFE_0005, "R8 write home hit");
        access(1'b0, mk(21'h000100, 3, 5), 32'h0, "R8 read back");
    endtask

    task automatic t_swap();
        access(1'b0, mk(21'h000104, 3, 1), 32'h0, "R6 spill first block");
        access(1'b0, mk(21'h000100, 3, 5), 32'h0, "R4 R10 other-way hit keeps write");
        access(1'b0, mk(21'h000100, 3, 2), 32'h0, "R4 swapped block now home");
        access(1'b0, mk(21'h000104, 3, 1), 32'h0, "R4 previous occupant moved");
    endtask

    task automatic t_spill_wrap();
        access(1'b0, mk(21'h000108, 3, 3), 32'h0, "R6 spill into empty way");
        access(1'b0, mk(21'h00010C, 3, 4), 32'h0, "R7 pointer steps");
        access(1'b0, mk(21'h000110, 3, 6), 32'h0, "R7 pointer wraps past home");
        access(1'b0, mk(21'h000100, 3, 5), 32'h0, "R6 evicted block misses");
        access(1'b0, mk(21'h00010C, 3, 4), 32'h0, "R6 R10 spilled block survives");
    endtask

    task automatic t_distinct_homes();
        for (int m = 0; m < 4; m++) access(1'b0, mk(21'h000200 + 21'(m), 7, m), 32'h0, "R2 fill own home");
        for (int m = 0; m < 4; m++) access(1'b0, mk(21'h000200 + 21'(m), 7, 9), 32'h0, "R2 R3 each home hits");
    endtask

    task automatic t_write_paths();
        access(1'b1, mk(21'h000301, 9, 7), 32'h1357_9BDF, "R8 write miss allocates");
        access(1'b1, mk(21'h000305, 9, 2), 32'h2468_ACE0, "R8 write miss with spill");
        access(1'b1, mk(21'h000301, 9, 8), 32'h0BAD_F00D, "R8 write other-way hit");
        access(1'b0, mk(21'h000301, 9, 7), 32'h0, "R10 earlier write kept");
        access(1'b0, mk(21'h000305, 9, 2), 32'h0, "R10 write kept after swap");
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 32; s++) begin
            rsel[s] = 0;
            for (int w = 0; w < 4; w++) rval[s][w] = 1'b0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_home_hits();
        t_swap();
        t_spill_wrap();
        t_distinct_homes();
        t_write_paths();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule